// File: doc/BRIEF.md
# Accumulator ALU with Status Flag Update

This block is the arithmetic and logic datapath of a small accumulator processor. One operation code selects among bitwise logic, binary add and subtract with carry, four single-bit shift and rotate forms, increment, decrement, compare and bit test. The operands are the accumulator or index value (`opnd_a`) and a memory or routed register value (`opnd_m`). The block returns the 8-bit result and a write enable that says whether the result belongs in a register. It also returns the next status byte, built from the incoming one.

Each operation changes only its own subset of the status flags. Every other flag bit, including the decimal-mode and interrupt-disable bits, is copied from `flags_in`. Decimal arithmetic is not performed. Shift, rotate, increment and decrement work on `opnd_m`, so the caller routes the accumulator there for the accumulator forms. A status register inside the block takes the computed status byte when `step` is high.

Top module: `alu8_status_unit`

## Requirements
- R1: Codes 0 (OR), 1 (AND) and 2 (XOR) combine `opnd_a` with `opnd_m`, assert `wr_en`, set N (bit 7) to result bit 7 and Z (bit 1) when the result is zero, and copy V (bit 6) and C (bit 0) from `flags_in`.
- R2: Code 3 adds `opnd_a + opnd_m + C`, writes the low 8 bits, sets C to the carry out, V to signed overflow, and N and Z from the result.
- R3: Code 4 computes `opnd_a - opnd_m - (1 - C)`, writes the low 8 bits, sets C when no borrow occurred, V on signed overflow, and N and Z from the result.
- R4: Code 5 shifts `opnd_m` left: old bit 7 goes to C, bit 0 becomes 0, N and Z follow the result, and V is copied.
- R5: Code 6 shifts `opnd_m` right: old bit 0 goes to C, bit 7 becomes 0 so N is cleared, Z follows the result, and V is copied.
- R6: Code 7 rotates `opnd_m` left, with the old C going into bit 0 and old bit 7 into C. Code 8 rotates it right, with the old C going into bit 7 and old bit 0 into C. Both set N and Z from the result.
- R7: Codes 9 and 10 increment and decrement `opnd_m` modulo 256, assert `wr_en`, update only N and Z, and copy V and C.
- R8: Code 11 compares `opnd_a` with `opnd_m`. C is set when `opnd_a >= opnd_m` unsigned, Z on equality, and N takes bit 7 of the 8-bit difference. V is copied, `wr_en` is low and `result` equals `opnd_a`.
- R9: Code 12 tests bits. N takes `opnd_m` bit 7, V takes `opnd_m` bit 6, and Z is set when `opnd_a & opnd_m` is zero. C is copied, `wr_en` is low and `result` equals `opnd_a`.
- R10: Bits 5 to 2 of the status byte, which include D (bit 3) and I (bit 2), always pass from `flags_in` to `flags_nxt`. For codes 13 to 15, `wr_en` is low, `result` equals `opnd_a` and `flags_nxt` equals `flags_in`.
- R11: `flags_q` clears to zero while `rst_n` is low. It loads `flags_nxt` on a rising clock edge with `step` high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Load `flags_nxt` into `flags_q` at the next edge |
| op | input | 4 | Operation code |
| opnd_a | input | W | Accumulator or index operand |
| opnd_m | input | W | Memory or routed operand |
| flags_in | input | 8 | Current status byte (N7 V6 D3 I2 Z1 C0) |
| result | output | W | Operation result |
| wr_en | output | 1 | Result is to be written to the destination |
| flags_nxt | output | 8 | Next status byte, combinational |
| flags_q | output | 8 | Registered status byte |

## Verification
The bench targets the carry and overflow boundaries of add and subtract. These cases are pos+pos giving a negative result, 0xFF+1 wrapping to zero with a carry, a borrow taken in when C is clear, and subtract overflow across signs. A design that treats C as a borrow, or that takes V from the wrong operand, returns flipped C or V bits on exactly these vectors. Rotates are driven with the incoming carry both set and clear, to catch a rotate that behaves as a plain shift. Compare and bit test are checked for a stray register write, and for V or C being disturbed when each must be kept. The reserved codes and the D/I pass-through are checked as well.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int FW     = 8;
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_I = 2;
  localparam int FLAG_D = 3;
  localparam int FLAG_V = 6;
  localparam int FLAG_N = 7;

  typedef enum logic [3:0] {
    OP_OR  = 4'd0,
    OP_AND = 4'd1,
    OP_XOR = 4'd2,
    OP_ADC = 4'd3,
    OP_SBC = 4'd4,
    OP_ASL = 4'd5,
    OP_LSR = 4'd6,
    OP_ROL = 4'd7,
    OP_ROR = 4'd8,
    OP_INC = 4'd9,
    OP_DEC = 4'd10,
    OP_CMP = 4'd11,
    OP_BIT = 4'd12
  } alu_op_e;

  localparam logic [3:0] OP_LAST = 4'd12;

  typedef struct packed {
    logic upd_n;
    logic upd_v;
    logic upd_z;
    logic upd_c;
    logic n;
    logic v;
    logic z;
    logic c;
  } flag_upd_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         cin,
  output logic [W-1:0] res,
  output flag_upd_t    fu
);

  function automatic logic [W:0] add_full(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic         ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic signed_ovf(input logic [W-1:0] x,
                                      input logic [W-1:0] y,
                                      input logic [W-1:0] s);
    return (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
  endfunction

  logic         is_add;
  logic         is_cmp;
  logic [W-1:0] m_eff;
  logic         c_eff;
  logic [W:0]   sum_full;
  logic         carry_out;
  logic         ovf;

  assign is_add    = (op == OP_ADC);
  assign is_cmp    = (op == OP_CMP);
  assign m_eff     = is_add ? m : ~m;
  assign c_eff     = is_cmp ? 1'b1 : cin;
  assign sum_full  = add_full(a, m_eff, c_eff);
  assign res       = sum_full[W-1:0];
  assign carry_out = sum_full[W];
  assign ovf       = signed_ovf(a, m_eff, res);

  always_comb begin
    fu       = '0;
    fu.upd_n = 1'b1;
    fu.upd_z = 1'b1;
    fu.upd_c = 1'b1;
    fu.upd_v = !is_cmp;
    fu.n     = res[W-1];
    fu.z     = (res == '0);
    fu.c     = carry_out;
    fu.v     = ovf;
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] m,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);

  logic left;
  logic fill;

  assign left = (op == OP_ASL) || (op == OP_ROL);
  assign fill = ((op == OP_ROL) || (op == OP_ROR)) ? cin : 1'b0;

  always_comb begin
    if (left) begin
      res  = {m[W-2:0], fill};
      cout = m[W-1];
    end else begin
      res  = {fill, m[W-1:1]};
      cout = m[0];
    end
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  output logic [W-1:0] res,
  output logic         bit_n,
  output logic         bit_v,
  output logic         bit_z
);

  logic [W-1:0] masked;

  assign masked = a & m;
  assign bit_n  = m[W-1];
  assign bit_v  = m[W-2];
  assign bit_z  = (masked == '0);

  always_comb begin
    case (op)
      OP_OR:   res = a | m;
      OP_AND:  res = masked;
      OP_XOR:  res = a ^ m;
      OP_INC:  res = m + 1'b1;
      OP_DEC:  res = m - 1'b1;
      default: res = a;
    endcase
  end

endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] d,
  output logic [FW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [3:0]    op,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_m,
  input  logic [FW-1:0] flags_in,
  output logic [W-1:0]  result,
  output logic          wr_en,
  output logic [FW-1:0] flags_nxt,
  output logic [FW-1:0] flags_q
);

  logic [W-1:0] ar_res;
  flag_upd_t    ar_fu;
  logic [W-1:0] sh_res;
  logic         sh_c;
  logic [W-1:0] lg_res;
  logic         bt_n;
  logic         bt_v;
  logic         bt_z;
  flag_upd_t    fu;

  alu8_arith #(.W(W)) u_arith (
    .op  (op),
    .a   (opnd_a),
    .m   (opnd_m),
    .cin (flags_in[FLAG_C]),
    .res (ar_res),
    .fu  (ar_fu)
  );

  alu8_shift #(.W(W)) u_shift (
    .op   (op),
    .m    (opnd_m),
    .cin  (flags_in[FLAG_C]),
    .res  (sh_res),
    .cout (sh_c)
  );

  alu8_logic #(.W(W)) u_logic (
    .op    (op),
    .a     (opnd_a),
    .m     (opnd_m),
    .res   (lg_res),
    .bit_n (bt_n),
    .bit_v (bt_v),
    .bit_z (bt_z)
  );

  always_comb begin
    fu     = '0;
    result = opnd_a;
    wr_en  = 1'b0;
    case (op)
      OP_OR, OP_AND, OP_XOR, OP_INC, OP_DEC: begin
        result   = lg_res;
        wr_en    = 1'b1;
        fu.upd_n = 1'b1;
        fu.upd_z = 1'b1;
        fu.n     = lg_res[W-1];
        fu.z     = (lg_res == '0);
      end
      OP_ADC, OP_SBC: begin
        result = ar_res;
        wr_en  = 1'b1;
        fu     = ar_fu;
      end
      OP_CMP: begin
        fu = ar_fu;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        result   = sh_res;
        wr_en    = 1'b1;
        fu.upd_n = 1'b1;
        fu.upd_z = 1'b1;
        fu.upd_c = 1'b1;
        fu.n     = sh_res[W-1];
        fu.z     = (sh_res == '0);
        fu.c     = sh_c;
      end
      OP_BIT: begin
        fu.upd_n = 1'b1;
        fu.upd_v = 1'b1;
        fu.upd_z = 1'b1;
        fu.n     = bt_n;
        fu.v     = bt_v;
        fu.z     = bt_z;
      end
      default: ;
    endcase
  end

  always_comb begin
    flags_nxt = flags_in;
    if (fu.upd_n) flags_nxt[FLAG_N] = fu.n;
    if (fu.upd_v) flags_nxt[FLAG_V] = fu.v;
    if (fu.upd_z) flags_nxt[FLAG_Z] = fu.z;
    if (fu.upd_c) flags_nxt[FLAG_C] = fu.c;
  end

  alu8_status_reg u_sreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (step),
    .d     (flags_nxt),
    .q     (flags_q)
  );

endmodule

// File: rtl/alu8_status_unit_chk.sv
module alu8_status_unit_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic [3:0]    op,
  input logic [W-1:0]  opnd_a,
  input logic [W-1:0]  opnd_m,
  input logic [FW-1:0] flags_in,
  input logic [W-1:0]  result,
  input logic          wr_en,
  input logic [FW-1:0] flags_nxt,
  input logic [FW-1:0] flags_q
);

  logic nz_only_op;
  logic rsvd_op;

  assign nz_only_op = (op == OP_OR) || (op == OP_AND) || (op == OP_XOR) ||
                      (op == OP_INC) || (op == OP_DEC);
  assign rsvd_op    = (op > OP_LAST);

  a_r1_nz_only: assert property (@(posedge clk) disable iff (!rst_n)
    nz_only_op |-> (wr_en && flags_nxt[FLAG_V] == flags_in[FLAG_V] &&
                    flags_nxt[FLAG_C] == flags_in[FLAG_C]));

  a_r5_lsr_clears_n: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LSR) |-> (!flags_nxt[FLAG_N] && flags_nxt[FLAG_C] == opnd_m[0]));

  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP) |-> (!wr_en && result == opnd_a &&
                        flags_nxt[FLAG_V] == flags_in[FLAG_V]));

  a_r9_bit_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BIT) |-> (!wr_en && flags_nxt[FLAG_N] == opnd_m[W-1] &&
                        flags_nxt[FLAG_V] == opnd_m[W-2] &&
                        flags_nxt[FLAG_C] == flags_in[FLAG_C]));

  a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    flags_nxt[5:2] == flags_in[5:2]);

  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_op |-> (!wr_en && flags_nxt == flags_in));

  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (flags_q == $past(flags_nxt)));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(flags_q));

endmodule

bind alu8_status_unit alu8_status_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step      (step),
  .op        (op),
  .opnd_a    (opnd_a),
  .opnd_m    (opnd_m),
  .flags_in  (flags_in),
  .result    (result),
  .wr_en     (wr_en),
  .flags_nxt (flags_nxt),
  .flags_q   (flags_q)
);

// File: tb/alu8_status_unit_bench.sv
module alu8_status_unit_bench;

  localparam int NV = 24;

  // {tag(24), op(4), a(8), m(8), flags_in(8), exp_res(8), exp_wr(1), exp_flags(8)}
  localparam logic [68:0] VEC [NV] = '{
    {"R1 ", 4'd0,  8'h0F, 8'hF0, 8'h00, 8'hFF, 1'b1, 8'h80},
    {"R1 ", 4'd1,  8'h0F, 8'hF0, 8'h41, 8'h00, 1'b1, 8'h43},
    {"R1 ", 4'd2,  8'hAA, 8'h55, 8'h0C, 8'hFF, 1'b1, 8'h8C},
    {"R2 ", 4'd3,  8'h50, 8'h50, 8'h00, 8'hA0, 1'b1, 8'hC0},
    {"R2 ", 4'd3,  8'hFF, 8'h01, 8'h00, 8'h00, 1'b1, 8'h03},
    {"R2 ", 4'd3,  8'h01, 8'h01, 8'h01, 8'h03, 1'b1, 8'h00},
    {"R3 ", 4'd4,  8'h50, 8'hF0, 8'h01, 8'h60, 1'b1, 8'h00},
    {"R3 ", 4'd4,  8'h50, 8'hB0, 8'h01, 8'hA0, 1'b1, 8'hC0},
    {"R3 ", 4'd4,  8'h05, 8'h05, 8'h00, 8'hFF, 1'b1, 8'h80},
    {"R3 ", 4'd4,  8'h05, 8'h03, 8'h01, 8'h02, 1'b1, 8'h01},
    {"R4 ", 4'd5,  8'h77, 8'h81, 8'h40, 8'h02, 1'b1, 8'h41},
    {"R4 ", 4'd5,  8'h77, 8'h40, 8'h3C, 8'h80, 1'b1, 8'hBC},
    {"R5 ", 4'd6,  8'h77, 8'h01, 8'h80, 8'h00, 1'b1, 8'h03},
    {"R6 ", 4'd7,  8'h77, 8'h80, 8'h01, 8'h01, 1'b1, 8'h01},
    {"R6 ", 4'd8,  8'h77, 8'h01, 8'h01, 8'h80, 1'b1, 8'h81},
    {"R6 ", 4'd8,  8'h77, 8'h02, 8'h00, 8'h01, 1'b1, 8'h00},
    {"R7 ", 4'd9,  8'h77, 8'hFF, 8'h41, 8'h00, 1'b1, 8'h43},
    {"R7 ", 4'd10, 8'h77, 8'h00, 8'h00, 8'hFF, 1'b1, 8'h80},
    {"R8 ", 4'd11, 8'h40, 8'h40, 8'h40, 8'h40, 1'b0, 8'h43},
    {"R8 ", 4'd11, 8'h10, 8'h20, 8'h01, 8'h10, 1'b0, 8'h80},
    {"R8 ", 4'd11, 8'h20, 8'h10, 8'h00, 8'h20, 1'b0, 8'h01},
    {"R9 ", 4'd12, 8'h01, 8'hC0, 8'h01, 8'h01, 1'b0, 8'hC3},
    {"R9 ", 4'd12, 8'hFF, 8'h3F, 8'hC0, 8'hFF, 1'b0, 8'h00},
    {"R10", 4'd13, 8'h12, 8'h34, 8'h5A, 8'h12, 1'b0, 8'h5A}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       step;
  logic [3:0] op;
  logic [7:0] opnd_a;
  logic [7:0] opnd_m;
  logic [7:0] flags_in;
  logic [7:0] result;
  logic       wr_en;
  logic [7:0] flags_nxt;
  logic [7:0] flags_q;

  int  n_tests = 0;
  int  n_fail  = 0;
  logic done   = 1'b0;

  always #10 clk = ~clk;

  alu8_status_unit u_alu8_status_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .op        (op),
    .opnd_a    (opnd_a),
    .opnd_m    (opnd_m),
    .flags_in  (flags_in),
    .result    (result),
    .wr_en     (wr_en),
    .flags_nxt (flags_nxt),
    .flags_q   (flags_q)
  );

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [7:0] a,
                       input logic [7:0] m, input logic [7:0] f);
    op = o; opnd_a = a; opnd_m = m; flags_in = f;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    step  = 1'b0;
    drive(4'd0, 8'h00, 8'h00, 8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", "reset flags_q", flags_q, 8'h00);
    rst_n = 1'b1;

    // table walk, combinational outputs
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][44:41], VEC[i][40:33], VEC[i][32:25], VEC[i][24:17]);
      #5;
      check($sformatf("%s", VEC[i][68:45]), "result",    result,        VEC[i][16:9]);
      check($sformatf("%s", VEC[i][68:45]), "wr_en",     {7'd0, wr_en}, {7'd0, VEC[i][8]});
      check($sformatf("%s", VEC[i][68:45]), "flags_nxt", flags_nxt,     VEC[i][7:0]);
    end

    // R10: remaining reserved codes leave everything alone
    for (int c = 14; c < 16; c++) begin
      @(negedge clk);
      drive(c[3:0], 8'h9C, 8'h63, 8'hA5);
      #5;
      check("R10", "reserved result", result, 8'h9C);
      check("R10", "reserved wr_en", {7'd0, wr_en}, 8'h00);
      check("R10", "reserved flags", flags_nxt, 8'hA5);
    end

    // R11: step loads the computed status byte
    @(negedge clk);
    drive(4'd3, 8'h50, 8'h50, 8'h0C);   // add overflow: N V D I -> CC
    step = 1'b1;
    @(posedge clk);
    @(negedge clk);
    step = 1'b0;
    check("R11", "flags_q load", flags_q, 8'hCC);

    // R11: no step, register holds while inputs move
    drive(4'd0, 8'h00, 8'h00, 8'hFF);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R11", "flags_q hold", flags_q, 8'hCC);

    // R11: asynchronous reset clears mid-run
    rst_n = 1'b0;
    #2;
    check("R11", "async reset", flags_q, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule